// File: doc/BRIEF.md
# Bf16 Tile Multiply-Accumulate Engine

The engine produces one 16x16 block of a matrix product. Operand A arrives as 16 rows running along the reduction dimension K. Operand B arrives transposed, as 16 columns that also run along K. Every product is formed from two bf16 values and added into a per-element fp32 accumulator. The work is split into K tiles of 16 slices each, and each tile updates all 256 accumulators as D = A·B + C, with the accumulator standing in for C.

A start pulse carries the tile count. Operand slices then enter through a valid/ready port, one k-slice per beat. Two slice buffers take turns. While one buffer feeds the multipliers, the next tile is written into the other. When the last tile has been consumed, the 256 accumulators leave one per cycle in row-major order, and a done pulse follows.

Top module: `bf16_tile_mac`

## Requirements
- R1: Each output element (i,j) equals the fp32 sum over k of A[i][k]*B[j][k]. Products are formed exactly from the bf16 operands (1 sign, 8 exponent, 7 mantissa bits, read as the top half of an fp32 word) and are added in increasing k order.
- R2: Every accumulation rounds toward zero. An exact cancellation gives +0 (32'h00000000).
- R3: An operand whose exponent field is zero counts as zero, whatever its mantissa.
- R4: A beat is one k-slice. A[i][k] sits at inData[16*i +: 16] and B[j][k] at inData[256+16*j +: 16]. Beats arrive in increasing k within a tile, and tiles arrive in order.
- R5: A start pulse seen while idle with kTiles nonzero clears all accumulators and begins a run of kTiles tiles. A start pulse while a run or output stream is in progress is ignored.
- R6: The result stream is 256 consecutive cycles of outVal. Element (i,j) appears at stream position 16*i+j.
- R7: done is high for exactly one cycle, in the cycle right after the last stream element.
- R8: inRdy stays low once kTiles tiles have been accepted, and it is never high during the result stream.
- R9: Each tile takes 16 compute cycles. If start is sampled at clock edge 0 and a beat is offered every cycle, the first element is presented after edge 16*(kTiles+1).
- R10: If the next buffer is not yet full when a tile ends, compute stalls and the accumulators hold. Gaps in the input only delay the results and leave their values unchanged.
- R11: During reset and immediately after it, inRdy, outVal and done are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run; clears the accumulators |
| kTiles | input | 8 | Number of K tiles in the run |
| inVal | input | 1 | Operand beat valid |
| inRdy | output | 1 | Engine accepts an operand beat |
| inData | input | 512 | One k-slice: 16 A values, then 16 B values |
| outVal | output | 1 | Result element valid |
| outData | output | 32 | fp32 result element |
| done | output | 1 | One-cycle pulse after the stream |

## Verification
The assertions watch the stream on every cycle. They check that the stream length is exactly 256, that the single done pulse lands right after the last element, that inRdy stays quiet during output, and that a start pulse cannot cut a stream short. Only the bench scenarios can show the numbers themselves. These cover round-toward-zero against a value that round-to-nearest would bump, flush of subnormal operands, exact cancellation to +0, row-major ordering, accumulator clearing between runs, first-result latency, and unchanged results when the input pauses at tile boundaries.

// File: rtl/bf16_tile_mac_pkg.sv
package bf16_tile_mac_pkg;
  localparam int TILE    = 16;
  localparam int SLICE_W = $clog2(TILE);
  localparam int ELEMS   = TILE * TILE;
  localparam int IDX_W   = $clog2(ELEMS);
  localparam int BF_W    = 16;
  localparam int FP_W    = 32;
  localparam int BEAT_W  = 2 * TILE * BF_W;
  localparam int TCNT_W  = 8;

  typedef struct packed {
    logic               clrAcc;
    logic               wrEn;
    logic               wrBuf;
    logic [SLICE_W-1:0] wrSlice;
    logic               macEn;
    logic               rdBuf;
    logic [SLICE_W-1:0] rdSlice;
    logic [IDX_W-1:0]   outIdx;
  } strobe_t;

  // Exact bf16 x bf16 product as fp32; zero exponent field reads as zero.
  function automatic logic [FP_W-1:0] bfMul(input logic [BF_W-1:0] a, input logic [BF_W-1:0] b);
    logic        sgn;
    logic [15:0] p;
    logic [22:0] m;
    int          e;
    if (a[14:7] == 8'd0 || b[14:7] == 8'd0) return '0;
    sgn = a[15] ^ b[15];
    p = 16'({1'b1, a[6:0]}) * 16'({1'b1, b[6:0]});
    e = int'(a[14:7]) + int'(b[14:7]) - 127;
    if (p[15]) begin
      e = e + 1;
      m = {p[14:0], 8'b0};
    end else begin
      m = {p[13:0], 9'b0};
    end
    if (e <= 0) return '0;
    if (e >= 255) return {sgn, 8'hFE, 23'h7FFFFF};
    return {sgn, 8'(e), m};
  endfunction

  // fp32 addition, round toward zero, subnormal results flushed to zero.
  function automatic logic [FP_W-1:0] fpAddRtz(input logic [FP_W-1:0] x, input logic [FP_W-1:0] y);
    logic [31:0] big, sml;
    logic [26:0] mb, ms, shf;
    logic [27:0] sum;
    logic        hit;
    int          d, e, lz;
    if (x[30:23] == 8'd0) return (y[30:23] == 8'd0) ? '0 : y;
    if (y[30:23] == 8'd0) return x;
    if (x[30:0] >= y[30:0]) begin big = x; sml = y; end
    else begin big = y; sml = x; end
    d  = int'(big[30:23]) - int'(sml[30:23]);
    mb = {1'b1, big[22:0], 3'b0};
    ms = {1'b1, sml[22:0], 3'b0};
    if (d > 26) begin
      shf = 27'd1;
    end else begin
      shf = ms >> d;
      shf[0] = shf[0] | (|(ms & ((27'd1 << d) - 27'd1)));
    end
    if (big[31] == sml[31]) sum = {1'b0, mb} + {1'b0, shf};
    else                    sum = {1'b0, mb} - {1'b0, shf};
    if (sum == 28'd0) return '0;
    e = int'(big[30:23]);
    if (sum[27]) begin
      sum = {1'b0, sum[27:2], sum[1] | sum[0]};
      e = e + 1;
    end else begin
      lz = 0;
      hit = 1'b0;
      for (int i = 26; i >= 0; i--) begin
        if (!hit) begin
          if (sum[i]) hit = 1'b1;
          else lz = lz + 1;
        end
      end
      sum = sum << lz;
      e = e - lz;
    end
    if (e <= 0) return '0;
    if (e >= 255) return {big[31], 8'hFE, 23'h7FFFFF};
    return {big[31], 8'(e), sum[25:3]};
  endfunction
endpackage

// File: rtl/bf16_tile_mac_dp.sv
module bf16_tile_mac_dp
  import bf16_tile_mac_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [BEAT_W-1:0] beat,
  output logic [FP_W-1:0]   outData
);
  localparam int B_OFS = TILE * BF_W;

  logic [BEAT_W-1:0] sliceMem [2][TILE];
  logic [FP_W-1:0]   accQ     [ELEMS];
  logic [FP_W-1:0]   accNext  [ELEMS];
  logic [BEAT_W-1:0] rdBeat;

  always_ff @(posedge clk) begin
    if (stb.wrEn) sliceMem[stb.wrBuf][stb.wrSlice] <= beat;
  end

  assign rdBeat = sliceMem[stb.rdBuf][stb.rdSlice];

  for (genvar gi = 0; gi < TILE; gi++) begin : g_row
    for (genvar gj = 0; gj < TILE; gj++) begin : g_col
      localparam int IDX = gi * TILE + gj;
      assign accNext[IDX] = fpAddRtz(accQ[IDX],
                                     bfMul(rdBeat[gi*BF_W +: BF_W], rdBeat[B_OFS + gj*BF_W +: BF_W]));
    end
  end

  always_ff @(posedge clk) begin
    for (int n = 0; n < ELEMS; n++) begin
      if (!rstN || stb.clrAcc) accQ[n] <= '0;
      else if (stb.macEn)      accQ[n] <= accNext[n];
    end
  end

  assign outData = accQ[stb.outIdx];
endmodule

// File: rtl/bf16_tile_mac_ctrl.sv
module bf16_tile_mac_ctrl
  import bf16_tile_mac_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [TCNT_W-1:0] kTiles,
  input  logic              inVal,
  output logic              inRdy,
  output logic              outVal,
  output logic              done,
  output strobe_t           stb
);
  localparam logic [SLICE_W-1:0] LAST_SLICE = SLICE_W'(TILE - 1);
  localparam logic [IDX_W-1:0]   LAST_IDX   = IDX_W'(ELEMS - 1);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_DRAIN} state_e;

  state_e              state;
  logic [TCNT_W-1:0]   total, loaded, finished;
  logic                ldBuf, cpBuf;
  logic [SLICE_W-1:0]  ldSlice, cpSlice;
  logic [1:0]          full;
  logic [IDX_W-1:0]    outIdx;
  logic                doneQ;
  logic                launch, take, mac;

  always_comb begin
    launch = start && (state == S_IDLE) && (kTiles != '0);
    inRdy  = (state == S_RUN) && !full[ldBuf] && (loaded != total);
    take   = inVal && inRdy;
    mac    = (state == S_RUN) && full[cpBuf];
    stb.clrAcc  = launch;
    stb.wrEn    = take;
    stb.wrBuf   = ldBuf;
    stb.wrSlice = ldSlice;
    stb.macEn   = mac;
    stb.rdBuf   = cpBuf;
    stb.rdSlice = cpSlice;
    stb.outIdx  = outIdx;
  end

  assign outVal = (state == S_DRAIN);
  assign done   = doneQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      total <= '0; loaded <= '0; finished <= '0;
      ldBuf <= 1'b0; cpBuf <= 1'b0;
      ldSlice <= '0; cpSlice <= '0;
      full <= '0; outIdx <= '0; doneQ <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      case (state)
        S_IDLE: if (launch) begin
          state <= S_RUN;
          total <= kTiles; loaded <= '0; finished <= '0;
          ldBuf <= 1'b0; cpBuf <= 1'b0;
          ldSlice <= '0; cpSlice <= '0; full <= '0;
        end
        S_RUN: begin
          if (take) begin
            ldSlice <= ldSlice + 1'b1;
            if (ldSlice == LAST_SLICE) begin
              full[ldBuf] <= 1'b1;
              ldBuf <= ~ldBuf;
              loaded <= loaded + 1'b1;
            end
          end
          if (mac) begin
            cpSlice <= cpSlice + 1'b1;
            if (cpSlice == LAST_SLICE) begin
              full[cpBuf] <= 1'b0;
              cpBuf <= ~cpBuf;
              finished <= finished + 1'b1;
              if (finished == total - 1'b1) begin
                state <= S_DRAIN;
                outIdx <= '0;
              end
            end
          end
        end
        S_DRAIN: begin
          outIdx <= outIdx + 1'b1;
          if (outIdx == LAST_IDX) begin
            state <= S_IDLE;
            doneQ <= 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bf16_tile_mac.sv
module bf16_tile_mac
  import bf16_tile_mac_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [TCNT_W-1:0] kTiles,
  input  logic              inVal,
  output logic              inRdy,
  input  logic [BEAT_W-1:0] inData,
  output logic              outVal,
  output logic [FP_W-1:0]   outData,
  output logic              done
);
  strobe_t stb;

  bf16_tile_mac_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .kTiles(kTiles),
    .inVal(inVal), .inRdy(inRdy), .outVal(outVal), .done(done), .stb(stb)
  );

  bf16_tile_mac_dp u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .beat(inData), .outData(outData)
  );
endmodule

// File: rtl/bf16_tile_mac_chk.sv
module bf16_tile_mac_chk
  import bf16_tile_mac_pkg::*;
(
  input logic clk,
  input logic rstN,
  input logic start,
  input logic inRdy,
  input logic outVal,
  input logic done
);
  logic [IDX_W:0] runLen;

  always_ff @(posedge clk) begin
    if (!rstN)       runLen <= '0;
    else if (outVal) runLen <= runLen + 1'b1;
    else             runLen <= '0;
  end

  p_start_ignored_r5: assert property (@(posedge clk) disable iff (!rstN)
    (start && outVal && runLen != (IDX_W+1)'(ELEMS - 1)) |=> outVal);

  p_stream_bound_r6: assert property (@(posedge clk) disable iff (!rstN)
    outVal |-> runLen < (IDX_W+1)'(ELEMS));

  p_stream_full_r6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(outVal) |-> runLen == (IDX_W+1)'(ELEMS));

  p_done_after_stream_r7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(outVal) |-> done);

  p_done_single_r7: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_no_load_in_out_r8: assert property (@(posedge clk) disable iff (!rstN)
    outVal |-> !inRdy);
endmodule

bind bf16_tile_mac bf16_tile_mac_chk u_chk (
  .clk(clk), .rstN(rstN), .start(start), .inRdy(inRdy), .outVal(outVal), .done(done)
);

// File: tb/bf16_tile_mac_bench.sv
`timescale 1ns/1ps
module bf16_tile_mac_bench;
  import bf16_tile_mac_pkg::*;

  localparam int MAXK  = 64;
  localparam int LIMIT = 100000;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              start = 1'b0;
  logic [TCNT_W-1:0] kTiles = '0;
  logic              inVal = 1'b0;
  logic              inRdy;
  logic [BEAT_W-1:0] inData = '0;
  logic              outVal;
  logic [FP_W-1:0]   outData;
  logic              done;

  bf16_tile_mac u_bf16_tile_mac (
    .clk(clk), .rstN(rstN), .start(start), .kTiles(kTiles), .inVal(inVal),
    .inRdy(inRdy), .inData(inData), .outVal(outVal), .outData(outData), .done(done)
  );

  always #2.5 clk = ~clk;

  real         aVal [TILE][MAXK];
  real         bVal [TILE][MAXK];
  logic [15:0] aBits[TILE][MAXK];
  logic [15:0] bBits[TILE][MAXK];
  logic [31:0] expQ[$];
  int          nChk = 0, nFail = 0, cyc = 0, doneSeen = 0;
  string       curTag = "R1";
  logic        prevOut = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
    end
  endtask

  // Truncating real-to-fp32 conversion, used for exact dyadic values.
  function automatic logic [31:0] realToFp(input real r);
    logic        s;
    real         a, f;
    int          e;
    logic [22:0] m;
    if (r == 0.0) return 32'h0;
    s = (r < 0.0);
    a = s ? -r : r;
    e = 0;
    while (a >= 2.0) begin a = a / 2.0; e++; end
    while (a < 1.0)  begin a = a * 2.0; e--; end
    f = a - 1.0;
    for (int b = 22; b >= 0; b--) begin
      f = f * 2.0;
      if (f >= 1.0) begin m[b] = 1'b1; f = f - 1.0; end
      else m[b] = 1'b0;
    end
    return {s, 8'(e + 127), m};
  endfunction

  task automatic setA(input int i, input int k, input real v);
    logic [31:0] w;
    w = realToFp(v);
    aVal[i][k] = v;
    aBits[i][k] = w[31:16];
  endtask

  task automatic setB(input int j, input int k, input real v);
    logic [31:0] w;
    w = realToFp(v);
    bVal[j][k] = v;
    bBits[j][k] = w[31:16];
  endtask

  task automatic clearOps();
    for (int i = 0; i < TILE; i++)
      for (int k = 0; k < MAXK; k++) begin
        setA(i, k, 0.0);
        setB(i, k, 0.0);
      end
  endtask

  task automatic fillRandom();
    for (int i = 0; i < TILE; i++)
      for (int k = 0; k < MAXK; k++) begin
        setA(i, k, real'(int'($urandom_range(0, 14)) - 7) / 2.0);
        setB(i, k, real'(int'($urandom_range(0, 14)) - 7) / 2.0);
      end
  endtask

  // R6: expected stream in row-major order i*16+j.
  task automatic pushExpected(input int nT);
    for (int i = 0; i < TILE; i++)
      for (int j = 0; j < TILE; j++) begin
        real s;
        s = 0.0;
        for (int k = 0; k < nT * TILE; k++) s = s + aVal[i][k] * bVal[j][k];
        expQ.push_back(realToFp(s));
      end
  endtask

  task automatic runCase(input int nT, input int gap, input bit midStart, input string tag);
    int c0, d0;
    bit rdy;
    curTag = tag;
    pushExpected(nT);
    d0 = doneSeen;
    @(negedge clk);
    kTiles = TCNT_W'(nT);
    start = 1'b1;
    c0 = cyc;
    @(negedge clk);
    start = 1'b0;
    for (int t = 0; t < nT; t++) begin
      for (int k = 0; k < TILE; k++) begin
        if (gap > 0 && (k % 4) == 1) begin
          inVal = 1'b0;
          repeat (gap) @(negedge clk);
        end
        for (int i = 0; i < TILE; i++) begin
          inData[16*i +: 16]       = aBits[i][t*TILE + k];
          inData[256 + 16*i +: 16] = bBits[i][t*TILE + k];
        end
        inVal = 1'b1;
        if (midStart && t == 0 && k == 8) start = 1'b1;  // R5: ignored while busy
        do begin
          rdy = inRdy;
          @(posedge clk);
          @(negedge clk);
          start = 1'b0;
        end while (!rdy);
      end
    end
    inVal = 1'b0;
    check(inRdy == 1'b0, "R8", "inRdy after final tile", 32'(inRdy), 32'd0);
    while (!outVal) @(negedge clk);
    if (gap == 0)
      check((cyc - c0) == 17 + 16 * nT, "R9", "first result latency",
            32'(cyc - c0), 32'(17 + 16 * nT));
    while (doneSeen == d0) @(negedge clk);
    check(expQ.size() == 0, "R6", "elements left unseen", 32'(expQ.size()), 32'd0);
    repeat (3) @(negedge clk);
  endtask

  // Scoreboard monitor.
  always @(negedge clk) begin
    if (rstN) begin
      if (outVal) begin
        if (expQ.size() == 0) check(1'b0, "R6", "extra element", outData, 32'h0);
        else begin
          logic [31:0] e;
          e = expQ.pop_front();
          check(outData == e, curTag, "result element", outData, e);
        end
      end
      if (prevOut && !outVal) begin
        check(done == 1'b1, "R7", "done after stream", 32'(done), 32'd1);
        doneSeen++;
      end else if (done) begin
        check(1'b0, "R7", "done out of place", 32'(done), 32'd0);
      end
      prevOut = outVal;
    end
  end

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cyc > LIMIT) begin
      nChk++;
      nFail++;
      $display("FAIL watchdog run exceeded actual=%0d expected<=%0d", cyc, LIMIT);
      report();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check({inRdy, outVal, done} == 3'b000, "R11", "outputs in reset", 32'({inRdy, outVal, done}), 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    check({inRdy, outVal, done} == 3'b000, "R11", "outputs after reset", 32'({inRdy, outVal, done}), 32'd0);

    // R1/R4: single tile, random dyadic values.
    fillRandom();
    runCase(1, 0, 1'b0, "R1");

    // R4/R9: three tiles back to back; also shows R5 clearing from the prior run.
    fillRandom();
    runCase(3, 0, 1'b0, "R4");

    // R10: input gaps stall compute at tile boundaries.
    fillRandom();
    runCase(2, 3, 1'b0, "R10");

    // R3: subnormal operands count as zero.
    fillRandom();
    aVal[2][3] = 0.0;  aBits[2][3] = 16'h0041;
    bVal[5][7] = 0.0;  bBits[5][7] = 16'h8012;
    aVal[9][12] = 0.0; aBits[9][12] = 16'h007F;
    runCase(1, 0, 1'b0, "R3");

    // R2: truncation, negative truncation and exact cancellation to +0.
    clearOps();
    setB(0, 0, 1.0); setB(0, 1, 1.0);
    setA(0, 0, 1.0);  setA(0, 1, 1.5 / 16777216.0);
    setA(1, 0, 1.5);  setA(1, 1, -1.5);
    setA(2, 0, -1.0); setA(2, 1, -1.5 / 16777216.0);
    runCase(1, 0, 1'b0, "R2");

    // R5: a start pulse mid-run is ignored.
    fillRandom();
    runCase(2, 0, 1'b1, "R5");

    report();
  end
endmodule